// File: doc/BRIEF.md
# Doorbell and Wired Interrupt Aggregator

This block collects sixty-four interrupt sources into a single request line for a parent interrupt controller. The lowest sources (21 by default) follow level-sensitive, active-high wired inputs. Every other source is a message source. A message source is raised when a write to a doorbell register carries that source's number as its data. Each source has a pending ("cause") bit and a disable ("mask") bit. The cause and mask bits are packed into two 32-bit words each, so source n sits in word n/32 at bit n%32.

Software drives the block through a plain valid/write/read register port. The cause words clear on a write of ones and ignore zeros. The mask words are plain read/write words. The doorbell is write-only. To initialise, software writes all ones to both cause words and both mask words, which clears every pending bit and disables every source. To service the line, software scans the two cause words, handles each set bit and then clears it. The request line is a registered OR of every pending bit whose mask bit is zero.

Top module: `irqagg_top`

## Requirements
- R1: Source n is held in word n/32 at bit n%32: source 31 reads as bit 31 of the cause word at offset 0x00, and source 32 reads as bit 0 of the cause word at offset 0x04.
- R2: A write to a cause word (offset 0x00 or 0x04) clears each pending bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R3: The mask words at offsets 0x20 and 0x24 take the written value in full and read it back. A mask bit of 1 blocks its source from the request line and a 0 lets it through.
- R4: A write of value d to the doorbell at offset 0x30 sets cause bit d when d is below 64. A doorbell write of 64 or more changes no cause bit.
- R5: For wired sources (index below 21), the cause bit is set on every clock edge at which the input is high. A clear written while the input is high does not take effect, and the same clear takes effect once the input is low.
- R6: A message source (index 21 to 63) stays pending after its doorbell write, with no further stimulus, until software clears it.
- R7: irq_out is high in the cycle after a cycle in which some cause bit is 1 and its mask bit is 0, and low otherwise.
- R8: After reset, every cause bit is 0, every mask bit is 1 and irq_out is 0.
- R9: A read of any offset other than the two cause and two mask words, including the doorbell, returns zero. reg_rdata is zero when no read is presented.
- R10: Writing all ones to both cause words and both mask words clears every pending message source and masks all sources, so irq_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wired_in | input | LVL_NUM (21) | Level-sensitive wired sources, active high |
| reg_valid | input | 1 | Register access presented this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data; the source number for a doorbell write |
| reg_rdata | output | 32 | Read data, combinational, valid in the cycle of the read |
| irq_out | output | 1 | Combined request to the parent controller, registered |

## Verification
A write or a high wired input changes the cause and mask words at the next rising edge. A read presented in any later cycle returns the new value combinationally in that same cycle. irq_out lags the cause and mask state by one more edge. The bench drives its inputs just after each rising edge and advances its reference model at that edge from those inputs. It compares irq_out and reg_rdata against the model halfway through the cycle, so each result is sampled in the cycle it is due and never across an edge.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
  localparam int SRC_NUM = 64;
  localparam int WORD_W  = 32;
  localparam int WORDS   = SRC_NUM / WORD_W;
  localparam int IDX_W   = $clog2(SRC_NUM);
  localparam int LVL_NUM = 21;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] CAUSE_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] MASK_BASE  = 8'h20;
  localparam logic [ADDR_W-1:0] DB_ADDR    = 8'h30;

  // offset of word w within a bank of consecutive 32-bit registers
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input int w);
    return base + ADDR_W'(4 * w);
  endfunction

  // doorbell data names a real source only below SRC_NUM
  function automatic logic db_in_range(input logic [WORD_W-1:0] d);
    return d < WORD_W'(SRC_NUM);
  endfunction

  function automatic logic [SRC_NUM-1:0] onehot_src(input logic [IDX_W-1:0] idx);
    return SRC_NUM'(1) << idx;
  endfunction
endpackage

// File: rtl/irqagg_decode.sv
`timescale 1ns/1ps
module irqagg_decode
  import irqagg_pkg::*;
(
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [SRC_NUM-1:0] clr_vec,
  output logic [WORDS-1:0]  mask_we,
  output logic              db_fire,
  output logic [IDX_W-1:0]  db_idx
);
  logic wr;
  assign wr = reg_valid && reg_write;

  for (genvar w = 0; w < WORDS; w++) begin : g_dec
    assign clr_vec[w*WORD_W +: WORD_W] =
      (wr && reg_addr == word_addr(CAUSE_BASE, w)) ? reg_wdata : '0;
    assign mask_we[w] = wr && reg_addr == word_addr(MASK_BASE, w);
  end

  assign db_fire = wr && reg_addr == DB_ADDR && db_in_range(reg_wdata);
  assign db_idx  = reg_wdata[IDX_W-1:0];
endmodule

// File: rtl/irqagg_word_regs.sv
`timescale 1ns/1ps
module irqagg_word_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] set,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] mask_q
);
  // a set arriving in the same cycle as a clear of that bit wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= (cause_q & ~clr) | set;
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/irqagg_readmux.sv
`timescale 1ns/1ps
module irqagg_readmux
  import irqagg_pkg::*;
(
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [SRC_NUM-1:0] cause_q,
  input  logic [SRC_NUM-1:0] mask_q,
  output logic [WORD_W-1:0]  reg_rdata
);
  always_comb begin
    reg_rdata = '0;
    if (rd_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if (reg_addr == word_addr(CAUSE_BASE, w)) reg_rdata = cause_q[w*WORD_W +: WORD_W];
        if (reg_addr == word_addr(MASK_BASE, w))  reg_rdata = mask_q[w*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/irqagg_top.sv
`timescale 1ns/1ps
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int LVL_NUM = irqagg_pkg::LVL_NUM
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_NUM-1:0] wired_in,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               irq_out
);
  // named internal events, observed by the bound checker
  logic [SRC_NUM-1:0] clr_vec;
  logic [SRC_NUM-1:0] set_vec;
  logic [SRC_NUM-1:0] cause_q;
  logic [SRC_NUM-1:0] mask_q;
  logic [WORDS-1:0]   mask_we;
  logic               db_fire;
  logic [IDX_W-1:0]   db_idx;
  logic               pend_any;

  irqagg_decode u_dec (
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .clr_vec   (clr_vec),
    .mask_we   (mask_we),
    .db_fire   (db_fire),
    .db_idx    (db_idx)
  );

  assign set_vec = (db_fire ? onehot_src(db_idx) : '0) | SRC_NUM'(wired_in);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    irqagg_word_regs #(.W(WORD_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_vec[w*WORD_W +: WORD_W]),
      .set     (set_vec[w*WORD_W +: WORD_W]),
      .mask_we (mask_we[w]),
      .wdata   (reg_wdata),
      .cause_q (cause_q[w*WORD_W +: WORD_W]),
      .mask_q  (mask_q[w*WORD_W +: WORD_W])
    );
  end

  irqagg_readmux u_rd (
    .rd_en     (reg_valid && !reg_write),
    .reg_addr  (reg_addr),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .reg_rdata (reg_rdata)
  );

  assign pend_any = |(cause_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_any;
  end
endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int LVL_NUM = irqagg_pkg::LVL_NUM
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_NUM-1:0] wired_in,
  input logic [SRC_NUM-1:0] clr_vec,
  input logic [SRC_NUM-1:0] set_vec,
  input logic [SRC_NUM-1:0] cause_q,
  input logic [SRC_NUM-1:0] mask_q,
  input logic [WORDS-1:0]   mask_we,
  input logic               db_fire,
  input logic [IDX_W-1:0]   db_idx,
  input logic [WORD_W-1:0]  reg_wdata,
  input logic               irq_out
);
  localparam int HI_W = SRC_NUM - LVL_NUM;
  logic [HI_W-1:0] keep_hi;
  assign keep_hi = cause_q[SRC_NUM-1:LVL_NUM] & ~clr_vec[SRC_NUM-1:LVL_NUM];

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0));

  for (genvar w = 0; w < WORDS; w++) begin : g_mchk
    assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we[w] |=> (mask_q[w*WORD_W +: WORD_W] == $past(reg_wdata)));
  end

  assert_db_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    db_fire |=> cause_q[$past(db_idx)]);

  assert_level_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|wired_in) |=> ((cause_q[LVL_NUM-1:0] & $past(wired_in)) == $past(wired_in)));

  assert_msg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|keep_hi) |=> ((cause_q[SRC_NUM-1:LVL_NUM] & $past(keep_hi)) == $past(keep_hi)));

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_out);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|cause_q));
endmodule

bind irqagg_top irqagg_chk #(.LVL_NUM(LVL_NUM)) u_chk (.*);

// File: tb/irqagg_top_tb.sv
`timescale 1ns/1ps
module irqagg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] wired = '0;
  logic        v = 1'b0, w = 1'b0;
  logic [7:0]  a = '0;
  logic [31:0] d = '0;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  irqagg_top u_dut (
    .clk(clk), .rst_n(rst_n), .wired_in(wired), .reg_valid(v), .reg_write(w),
    .reg_addr(a), .reg_wdata(d), .reg_rdata(rdata), .irq_out(irq)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R8";
  bit    done = 1'b0;
  bit    m_cause[64], m_mask[64], m_next[64];
  bit    m_irq = 1'b0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input bit arr[64], input int wd);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = arr[wd*32 + i];
    return r;
  endfunction

  // reference model, advanced at each rising edge from the driven inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin m_cause[i] = 1'b0; m_mask[i] = 1'b1; end
      m_irq = 1'b0;
    end else begin
      bit any;
      any = 1'b0;
      for (int i = 0; i < 64; i++) any |= m_cause[i] & !m_mask[i];
      for (int i = 0; i < 64; i++) begin
        bit c;
        c = m_cause[i];
        if (v && w && a == 8'(4*(i/32)) && d[i%32]) c = 1'b0;
        if (i < 21 && wired[i]) c = 1'b1;
        if (v && w && a == 8'h30 && d == 32'(i)) c = 1'b1;
        m_next[i] = c;
        if (v && w && a == 8'(32 + 4*(i/32))) m_mask[i] = d[i%32];
      end
      m_cause = m_next;
      m_irq = any;
    end
  end

  // comparison mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp;
      check(irq === m_irq, "irq_out", {31'd0, irq}, {31'd0, m_irq});
      exp = '0;
      if (v && !w) begin
        case (a)
          8'h00: exp = pack(m_cause, 0);
          8'h04: exp = pack(m_cause, 1);
          8'h20: exp = pack(m_mask, 0);
          8'h24: exp = pack(m_mask, 1);
          default: exp = '0;
        endcase
      end
      check(rdata === exp, "reg_rdata", rdata, exp);
    end
  end

  task automatic bus(input bit wr, input logic [7:0] ad, input logic [31:0] dt);
    @(posedge clk); #2;
    v = 1'b1; w = wr; a = ad; d = dt;
    @(posedge clk); #2;
    v = 1'b0; w = 1'b0;
  endtask

  task automatic rd_all();
    bus(0, 8'h00, 0); bus(0, 8'h04, 0); bus(0, 8'h20, 0); bus(0, 8'h24, 0);
  endtask

  task automatic lvl(input logic [20:0] x);
    @(posedge clk); #2; wired = x;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R8: reset values
    cur_req = "R8";
    rd_all();
    // R10: initialisation writes
    cur_req = "R10";
    bus(1, 8'h30, 32'd40);
    bus(1, 8'h00, '1); bus(1, 8'h04, '1); bus(1, 8'h20, '1); bus(1, 8'h24, '1);
    rd_all();
    // R3: unmask and mask patterns
    cur_req = "R3";
    bus(1, 8'h20, 32'h0000_0000); bus(1, 8'h24, 32'hA5A5_0F0F);
    rd_all();
    bus(1, 8'h24, 32'h0000_0000);
    // R4: doorbell sets; out-of-range ignored
    cur_req = "R4";
    bus(1, 8'h30, 32'd21); bus(1, 8'h30, 32'd40); bus(1, 8'h30, 32'd63);
    rd_all();
    bus(1, 8'h30, 32'd64); bus(1, 8'h30, 32'd100); bus(1, 8'h30, 32'h8000_0005);
    rd_all();
    // R1: word boundary
    cur_req = "R1";
    bus(1, 8'h30, 32'd31); bus(1, 8'h30, 32'd32);
    bus(0, 8'h00, 0); bus(0, 8'h04, 0);
    // R6: message pending holds
    cur_req = "R6";
    repeat (10) @(posedge clk);
    bus(0, 8'h00, 0); bus(0, 8'h04, 0);
    // R2: W1C and zero-write no effect
    cur_req = "R2";
    bus(1, 8'h04, 32'h0000_0000); bus(0, 8'h04, 0);
    bus(1, 8'h04, 32'h0000_0100); bus(0, 8'h04, 0);
    bus(1, 8'h00, 32'h8020_0000); bus(0, 8'h00, 0);
    // R7: masking drives irq_out
    cur_req = "R7";
    bus(1, 8'h24, '1); repeat (3) @(posedge clk);
    bus(1, 8'h04, '1); bus(1, 8'h24, 32'h0);
    bus(1, 8'h30, 32'd50); repeat (3) @(posedge clk);
    bus(1, 8'h04, 32'h0004_0000); repeat (3) @(posedge clk);
    // R5: level sources, clear while high does not stick
    cur_req = "R5";
    lvl(21'h000008); repeat (2) @(posedge clk);
    bus(1, 8'h00, 32'h8); bus(0, 8'h00, 0);
    lvl(21'h100000); bus(1, 8'h00, 32'h8); bus(0, 8'h00, 0);
    lvl(21'h0); bus(1, 8'h00, 32'h0010_0000); bus(0, 8'h00, 0);
    lvl(21'h1FFFFF); lvl(21'h0);
    bus(0, 8'h00, 0); bus(1, 8'h00, '1); bus(0, 8'h00, 0);
    // R9: unmapped and doorbell reads, idle rdata
    cur_req = "R9";
    bus(1, 8'h30, 32'd33);
    bus(0, 8'h30, 0); bus(0, 8'h08, 0); bus(0, 8'h10, 0); bus(0, 8'hFC, 0);
    repeat (2) @(posedge clk);
    // R10: re-initialise with sources pending
    cur_req = "R10";
    bus(1, 8'h00, '1); bus(1, 8'h04, '1); bus(1, 8'h20, '1); bus(1, 8'h24, '1);
    rd_all();
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule